// File: doc/BRIEF.md
# Color-Filter Pixel-Rate Gain Selector

This block steers a per-pixel gain and offset choice for a sensor whose pixels sit behind a repeating color-filter mosaic. A register bank supplies four gain codes and four signed offset codes. On every pixel clock the block emits one 2-bit set index, and it passes on the gain and offset codes of that set. The index is read from one of two pattern words, one for even lines and one for odd lines. Each pattern word has four 2-bit slots, and each line can repeat one to four of them.

A level input marks the active pixels of a line. It is high for the whole active part of the line and low during blanking. While it is high, a slot position advances once per clock and wraps after the last used slot of the current line. When it falls, the position returns to slot 0 and the block swaps to the other pattern word. During blanking the outputs therefore already show the first pixel of the next line. Two further inputs select a single-set mode: an auxiliary-source select, and a pattern-enable flag that is low for single-channel operation. In that mode set 0 is forced while the line tracking carries on underneath.

Top module: `cfa_gain_select`

## Requirements
- R1: A synchronous active-high reset selects the even-line pattern at slot 0. In the cycle after reset, `sel_idx` equals `pat_row0[1:0]` when the pattern is enabled and the auxiliary select is low.
- R2: `gain_out` equals field `sel_idx` of `gain_regs` (bits `[8k+7:8k]` for index k), and `ofs_out` equals the same field of `ofs_regs`. Both follow `sel_idx` in the same cycle.
- R3: Slot p of a pattern word occupies bits `[2p+1:2p]`: slot 0 is `[1:0]`, slot 1 is `[3:2]`, slot 2 is `[5:4]`, slot 3 is `[7:6]`. Slot 0 is the first pixel of a line, and each later pixel uses the next slot.
- R4: `row_len[1:0]` gives the slot count of even lines and `row_len[3:2]` that of odd lines. A value n means n+1 slots. After the last used slot the position wraps to slot 0, so n=0 repeats slot 0 on every pixel.
- R5: While `line_active` is high, the slot position advances by one each clock. While it is low, the position is held at slot 0 from the next clock on, so the outputs show pixel 0 of the coming line.
- R6: Each high-to-low transition of `line_active` swaps the active pattern between even (`pat_row0`) and odd (`pat_row1`). The first line after reset uses the even pattern.
- R7: While `aux_mode` is high or `cfa_enable` is low, `sel_idx` is 0, so gain set 0 and offset set 0 are selected. Slot and line tracking continue unchanged during this time.
- R8: A reset asserted in the middle of an active line returns the block to the even pattern at slot 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Pixel clock |
| rst | input | 1 | Synchronous reset, active high |
| line_active | input | 1 | High during the active pixels of a line, low during blanking |
| aux_mode | input | 1 | Auxiliary source selected; forces set 0 |
| cfa_enable | input | 1 | Pattern sequencing enabled; low forces set 0 |
| pat_row0 | input | 8 | Even-line pattern, four 2-bit set indices |
| pat_row1 | input | 8 | Odd-line pattern, four 2-bit set indices |
| row_len | input | 4 | Slot counts minus one: [1:0] even line, [3:2] odd line |
| gain_regs | input | 32 | Four 8-bit gain codes, set k at [8k+7:8k] |
| ofs_regs | input | 32 | Four signed 8-bit offset codes, set k at [8k+7:8k] |
| gain_out | output | 8 | Gain code of the selected set |
| ofs_out | output | 8 | Signed offset code of the selected set |
| sel_idx | output | 2 | Index of the selected set |

## Verification
A wrong slot position or line flag shows directly on `sel_idx`, and through it on both codes, in the same cycle it is wrong. The bench therefore compares every cycle against an independent model of position and line parity. A wrap-length fault first appears on the pixel after the last used slot. A parity fault appears on the first blanking cycle after a line ends, because the outputs must then already carry pixel 0 of the other pattern. A bypass fault shows either as a nonzero index while set 0 is forced, or as a wrong slot once bypass is released mid-line.

// File: rtl/cfa_pkg.sv
package cfa_pkg;

    localparam int IDX_W  = 2;
    localparam int SLOTS  = 4;
    localparam int SETS   = 4;
    localparam int CODE_W = 8;

    typedef enum logic [0:0] {
        ROW_EVEN = 1'b0,
        ROW_ODD  = 1'b1
    } row_e;

endpackage

// File: rtl/cfa_row_seq.sv
module cfa_row_seq #(
    parameter int IDX_W = cfa_pkg::IDX_W
) (
    input  logic               clk,
    input  logic               rst,
    input  logic               line_active,
    input  logic [2*IDX_W-1:0] row_len,
    output cfa_pkg::row_e      row_o,
    output logic [IDX_W-1:0]   pos_o
);
    import cfa_pkg::*;

    typedef struct packed {
        row_e             row;
        logic [IDX_W-1:0] pos;
        logic             was_act;
    } seq_st_t;

    seq_st_t          st_d, st_q;
    logic [IDX_W-1:0] last_pos;

    always_comb begin
        last_pos = (st_q.row == ROW_ODD) ? row_len[2*IDX_W-1:IDX_W]
                                         : row_len[IDX_W-1:0];
        st_d         = st_q;
        st_d.was_act = line_active;
        if (line_active) begin
            st_d.pos = (st_q.pos == last_pos) ? '0 : st_q.pos + 1'b1;
        end else begin
            st_d.pos = '0;
        end
        if (st_q.was_act && !line_active) begin
            st_d.row = (st_q.row == ROW_EVEN) ? ROW_ODD : ROW_EVEN;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            st_q <= '{row: ROW_EVEN, pos: '0, was_act: 1'b0};
        end else begin
            st_q <= st_d;
        end
    end

    assign row_o = st_q.row;
    assign pos_o = st_q.pos;

    // R1 / R8: reset lands on the even pattern, slot 0
    p_reset_home_r8: assert property (@(posedge clk)
        rst |=> (st_q.pos == '0 && st_q.row == ROW_EVEN));

    // R5: blanking parks the position at slot 0
    p_blank_park_r5: assert property (@(posedge clk) disable iff (rst)
        !line_active |=> (st_q.pos == '0));

    // R5: active pixels step the position by one
    p_step_r5: assert property (@(posedge clk) disable iff (rst)
        (line_active && st_q.pos != last_pos)
        |=> (st_q.pos == IDX_W'($past(st_q.pos) + 1)));

    // R4: wrap after the last used slot
    p_wrap_r4: assert property (@(posedge clk) disable iff (rst)
        (line_active && st_q.pos == last_pos) |=> (st_q.pos == '0));

    // R6: end of an active line swaps the pattern
    p_swap_r6: assert property (@(posedge clk) disable iff (rst)
        (st_q.was_act && !line_active) |=> (st_q.row != $past(st_q.row)));

    // R6: no swap without a line ending
    p_keep_r6: assert property (@(posedge clk) disable iff (rst)
        !(st_q.was_act && !line_active) |=> $stable(st_q.row));

endmodule

// File: rtl/cfa_slot_pick.sv
module cfa_slot_pick #(
    parameter int IDX_W = cfa_pkg::IDX_W,
    parameter int SLOTS = cfa_pkg::SLOTS
) (
    input  logic [SLOTS*IDX_W-1:0] pat_even,
    input  logic [SLOTS*IDX_W-1:0] pat_odd,
    input  cfa_pkg::row_e          row_i,
    input  logic [IDX_W-1:0]       pos_i,
    input  logic                   bypass,
    output logic [IDX_W-1:0]       idx_o
);
    import cfa_pkg::*;

    logic [IDX_W-1:0] even_slot [SLOTS];
    logic [IDX_W-1:0] odd_slot  [SLOTS];
    logic [IDX_W-1:0] chosen;

    for (genvar g = 0; g < SLOTS; g++) begin : g_unpack
        assign even_slot[g] = pat_even[g*IDX_W +: IDX_W];
        assign odd_slot[g]  = pat_odd[g*IDX_W +: IDX_W];
    end

    always_comb begin
        chosen = (row_i == ROW_ODD) ? odd_slot[pos_i] : even_slot[pos_i];
        idx_o  = bypass ? '0 : chosen;
    end

endmodule

// File: rtl/cfa_bank_mux.sv
module cfa_bank_mux #(
    parameter int IDX_W  = cfa_pkg::IDX_W,
    parameter int SETS   = cfa_pkg::SETS,
    parameter int CODE_W = cfa_pkg::CODE_W
) (
    input  logic [SETS*CODE_W-1:0]  gain_flat,
    input  logic [SETS*CODE_W-1:0]  ofs_flat,
    input  logic [IDX_W-1:0]        idx_i,
    output logic [CODE_W-1:0]       gain_o,
    output logic signed [CODE_W-1:0] ofs_o
);
    logic [CODE_W-1:0] gain_set [SETS];
    logic [CODE_W-1:0] ofs_set  [SETS];

    for (genvar k = 0; k < SETS; k++) begin : g_sets
        assign gain_set[k] = gain_flat[k*CODE_W +: CODE_W];
        assign ofs_set[k]  = ofs_flat[k*CODE_W +: CODE_W];
    end

    always_comb begin
        gain_o = gain_set[idx_i];
        ofs_o  = $signed(ofs_set[idx_i]);
    end

endmodule

// File: rtl/cfa_gain_select.sv
module cfa_gain_select #(
    parameter int IDX_W  = cfa_pkg::IDX_W,
    parameter int SLOTS  = cfa_pkg::SLOTS,
    parameter int SETS   = cfa_pkg::SETS,
    parameter int CODE_W = cfa_pkg::CODE_W
) (
    input  logic                     clk,
    input  logic                     rst,
    input  logic                     line_active,
    input  logic                     aux_mode,
    input  logic                     cfa_enable,
    input  logic [SLOTS*IDX_W-1:0]   pat_row0,
    input  logic [SLOTS*IDX_W-1:0]   pat_row1,
    input  logic [2*IDX_W-1:0]       row_len,
    input  logic [SETS*CODE_W-1:0]   gain_regs,
    input  logic [SETS*CODE_W-1:0]   ofs_regs,
    output logic [CODE_W-1:0]        gain_out,
    output logic signed [CODE_W-1:0] ofs_out,
    output logic [IDX_W-1:0]         sel_idx
);
    import cfa_pkg::*;

    row_e             cur_row;
    logic [IDX_W-1:0] cur_pos;
    logic             force_set0;

    assign force_set0 = aux_mode | ~cfa_enable;

    cfa_row_seq #(.IDX_W(IDX_W)) u_seq (
        .clk         (clk),
        .rst         (rst),
        .line_active (line_active),
        .row_len     (row_len),
        .row_o       (cur_row),
        .pos_o       (cur_pos)
    );

    cfa_slot_pick #(.IDX_W(IDX_W), .SLOTS(SLOTS)) u_pick (
        .pat_even (pat_row0),
        .pat_odd  (pat_row1),
        .row_i    (cur_row),
        .pos_i    (cur_pos),
        .bypass   (force_set0),
        .idx_o    (sel_idx)
    );

    cfa_bank_mux #(.IDX_W(IDX_W), .SETS(SETS), .CODE_W(CODE_W)) u_mux (
        .gain_flat (gain_regs),
        .ofs_flat  (ofs_regs),
        .idx_i     (sel_idx),
        .gain_o    (gain_out),
        .ofs_o     (ofs_out)
    );

    // R7: single-set mode forces index 0
    p_force_set0_r7: assert property (@(posedge clk) disable iff (rst)
        force_set0 |-> (sel_idx == '0));

    // R2: gain follows the selected index
    p_gain_follow_r2: assert property (@(posedge clk) disable iff (rst)
        gain_out == gain_regs[sel_idx*CODE_W +: CODE_W]);

    // R2: offset follows the selected index
    p_ofs_follow_r2: assert property (@(posedge clk) disable iff (rst)
        ofs_out == $signed(ofs_regs[sel_idx*CODE_W +: CODE_W]));

    // R3: with bypass off the index comes from a slot of the active pattern
    p_slot_src_r3: assert property (@(posedge clk) disable iff (rst)
        (!force_set0 && cur_row == ROW_EVEN)
        |-> (sel_idx == pat_row0[cur_pos*IDX_W +: IDX_W]));

endmodule

// File: tb/sim_cfa_gain_select.sv
module sim_cfa_gain_select;

    logic clk = 1'b0;
    always #4 clk = ~clk;

    logic              rst, line_active, aux_mode, cfa_enable;
    logic [7:0]        pat_row0, pat_row1;
    logic [3:0]        row_len;
    logic [31:0]       gain_regs, ofs_regs;
    logic [7:0]        gain_out;
    logic signed [7:0] ofs_out;
    logic [1:0]        sel_idx;

    int n_checks = 0;
    int n_fail   = 0;
    bit finished = 1'b0;
    int g_tab [4];
    int o_tab [4];
    int m_row, m_pos, m_prev;

    cfa_gain_select u0 (
        .clk(clk), .rst(rst), .line_active(line_active), .aux_mode(aux_mode),
        .cfa_enable(cfa_enable), .pat_row0(pat_row0), .pat_row1(pat_row1),
        .row_len(row_len), .gain_regs(gain_regs), .ofs_regs(ofs_regs),
        .gain_out(gain_out), .ofs_out(ofs_out), .sel_idx(sel_idx)
    );

    // behavioural reference: line parity and slot position
    always @(posedge clk) begin
        int span;
        if (rst) begin
            m_row = 0; m_pos = 0; m_prev = 0;
        end else begin
            span = (m_row != 0) ? int'(row_len[3:2]) + 1 : int'(row_len[1:0]) + 1;
            if (line_active) m_pos = (m_pos + 1) % span;
            else             m_pos = 0;
            if (m_prev != 0 && !line_active) m_row = 1 - m_row;
            m_prev = line_active ? 1 : 0;
        end
    end

    function automatic int ref_idx();
        logic [7:0] w;
        if (aux_mode || !cfa_enable) return 0;
        w = (m_row != 0) ? pat_row1 : pat_row0;
        return int'((w >> (2 * m_pos)) & 8'd3);
    endfunction

    task automatic chk(string req, string what, int act, int exp);
        n_checks++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s %s: actual=%0d expected=%0d at %0t", req, what, act, exp, $time);
        end
    endtask

    task automatic load_banks();
        for (int k = 0; k < 4; k++) begin
            gain_regs[k*8 +: 8] = g_tab[k][7:0];
            ofs_regs[k*8 +: 8]  = o_tab[k][7:0];
        end
    endtask

    // one pixel: compare against the model, then cross the clock edge
    task automatic tick();
        int e;
        #1;
        e = ref_idx();
        chk("R3", "sel_idx vs model", int'(sel_idx), e);
        chk("R2", "gain_out vs model", int'(gain_out), g_tab[e]);
        chk("R2", "ofs_out vs model", int'(ofs_out), o_tab[e]);
        @(posedge clk);
        #1;
    endtask

    task automatic at(bit act, string req, int exp_idx);
        line_active = act;
        #1;
        chk(req, "sel_idx", int'(sel_idx), exp_idx);
        tick();
    endtask

    initial begin
        repeat (60000) @(posedge clk);
        if (!finished) begin
            n_fail++;
            $display("FAIL watchdog: actual=timeout expected=completion");
            $display("  [TB] %0d tests run, %0d failed", n_checks, n_fail);
            $finish;
        end
    end

    initial begin
        int lfsr;
        int run;
        g_tab[0] = 8'h10; g_tab[1] = 8'h20; g_tab[2] = 8'h30; g_tab[3] = 8'h40;
        o_tab[0] = -3;    o_tab[1] = 5;     o_tab[2] = -100;  o_tab[3] = 127;
        load_banks();
        pat_row0 = 8'hE4;    // slots 0,1,2,3
        pat_row1 = 8'h1B;    // slots 3,2,1,0
        row_len  = 4'b1101;  // even: 2 slots, odd: 4 slots
        aux_mode = 1'b0; cfa_enable = 1'b1; line_active = 1'b0;
        rst = 1'b1;
        @(posedge clk); #1;
        tick(); tick(); tick();
        rst = 1'b0;

        // R1: reset state
        #1;
        chk("R1", "sel_idx after reset", int'(sel_idx), 0);
        chk("R1", "gain_out after reset", int'(gain_out), 8'h10);
        tick();

        // even line, 2-slot wrap
        at(1, "R3", 0);
        at(1, "R2", 1);
        at(1, "R4", 0);
        at(1, "R3", 1);
        at(1, "R5", 0);
        line_active = 1'b0; tick();
        at(0, "R5", 3);
        at(0, "R5", 3);

        // odd line, 4-slot
        at(1, "R6", 3);
        at(1, "R3", 2);
        at(1, "R3", 1);
        at(1, "R4", 0);
        at(1, "R4", 3);
        at(1, "R3", 2);
        line_active = 1'b0; tick(); tick();

        // even line with auxiliary bypass mid-line
        at(1, "R6", 0);
        at(1, "R3", 1);
        aux_mode = 1'b1;
        at(1, "R7", 0);
        at(1, "R7", 0);
        aux_mode = 1'b0;
        at(1, "R7", 0);
        at(1, "R7", 1);
        line_active = 1'b0; row_len = 4'b0000; tick(); tick();

        // odd line with single slot
        at(1, "R4", 3);
        at(1, "R4", 3);
        at(1, "R4", 3);
        line_active = 1'b0; row_len = 4'b1101; cfa_enable = 1'b0; tick(); tick();

        // even line with sequencing disabled
        at(1, "R7", 0);
        at(1, "R7", 0);
        at(1, "R7", 0);
        line_active = 1'b0; cfa_enable = 1'b1; tick(); tick();

        // odd line interrupted by reset
        at(1, "R6", 3);
        at(1, "R3", 2);
        rst = 1'b1; line_active = 1'b1; tick();
        rst = 1'b0;
        at(1, "R8", 0);
        at(1, "R8", 1);
        line_active = 1'b0; tick();
        at(0, "R8", 3);

        // pseudo-random lines and settings
        lfsr = 32'h1ACE_5EED;
        for (int n = 0; n < 120; n++) begin
            lfsr = (lfsr << 1) ^ (((lfsr >>> 31) & 1) != 0 ? 32'h04C1_1DB7 : 0);
            pat_row0 = lfsr[7:0];
            pat_row1 = lfsr[15:8];
            if (n % 7 == 3) row_len = lfsr[19:16];
            aux_mode   = (lfsr[23:20] == 4'h5);
            cfa_enable = (lfsr[27:24] != 4'h9);
            run = 1 + int'(lfsr[30:28]) * 2;
            line_active = 1'b1;
            for (int p = 0; p < run; p++) tick();
            line_active = 1'b0;
            for (int p = 0; p < 1 + (n % 3); p++) tick();
        end

        finished = 1'b1;
        $display("  [TB] %0d tests run, %0d failed", n_checks, n_fail);
        $finish;
    end

endmodule